// File: doc/BRIEF.md
# NEC pulse-distance frame decoder

This block turns one packet of run-length symbols into an NEC-style 32-bit code. Each symbol is one byte. Bit 7 gives the level: 1 for a pulse (mark), 0 for a space. Bits 6:0 hold the run length minus one, in samples. The decoder first looks for the long leading pulse, then the leading space. After that it reads 32 data bits, one from the length of each space that follows a short pulse. A packet closes with a beat that carries the end-of-packet marker. One clock later the decoder gives a single-cycle result strobe, with the code and a flag that says whether the command byte matches its complement.

Adjacent symbols of the same level are summed into one run, so a run may be split across any number of symbols. All thresholds are fixed sample counts, set by parameters. Any framing error gives the all-ones code. Once the error is seen, the rest of the packet is ignored. After every end-of-packet beat the decoder goes back to the leader search.

The controller has six named states:
- `S_HUNT`: leading-pulse search.
- `S_GAP`: leading-space check.
- `S_MARK`: data pulse.
- `S_SPACE`: data space.
- `S_FULL`: all bits taken.
- `S_FAULT`: error seen.

Its transitions are:
- hunt-to-gap when the leader is accepted.
- gap-to-mark when the leading space is accepted.
- mark-to-space when a short pulse ends.
- space-to-mark when a bit is decoded.
- space-to-full when the last bit is decoded.
- mark-to-fault on a long pulse.
- space-to-fault on a long space.
- any-to-hunt on end of packet.

Top module: `nec_frame_decoder`

## Requirements
- R1: Consecutive symbols of the same level add up, each contributing its length field plus one. The run count saturates at 255 and never wraps. For example, a data space sent as 128+128+10 samples counts as over 53 and is an error.
- R2: After an end of packet or reset, the pulse count starts with a credit of 80. A pulse run is accepted as the leader when its count exceeds 80 at the next space. Otherwise the count is cleared to 0 without credit, and the search goes on.
- R3: After the leader, the space count must exceed 40 when the next pulse arrives. If it does not, the count is cleared and the check repeats. A packet that ends during the leader search or the leader-space check yields 0xFFFFFFFF.
- R4: During data decoding, a pulse run of more than 26 samples is an error. A pulse run of exactly 26 samples is accepted.
- R5: A data space is closed by the next pulse. It is an error if its run is longer than 53 samples. A run longer than 26 samples decodes as 1, and a run of 26 or fewer decodes as 0.
- R6: Decoded bits fill the code from bit 0 upward. After 32 bits, all further symbols of the packet are ignored.
- R7: After any error, the remaining symbols of the packet are ignored, and the result is 0xFFFFFFFF with the valid flag low.
- R8: The valid flag is high only when code bits 23:16 XOR code bits 31:24 equal 0xFF. Bits 15:0 (the address bytes) are not checked.
- R9: A packet that ends during data decoding returns the bits decoded so far, with the upper bits zero. The valid flag follows the rule of R8.
- R10: The result strobe is high for exactly the one cycle after the accepted end-of-packet beat. The data byte of that beat is ignored. The next packet starts in the leader search.
- R11: During reset, the strobe, code and valid flag are all 0. The input is always ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | Symbol beat offered |
| sym_ready | output | 1 | Beat accepted (always high) |
| sym_data | input | 8 | Bit 7 level (1 = pulse), bits 6:0 length minus one |
| sym_eop | input | 1 | Beat is the end-of-packet marker; its data is ignored |
| res_strobe | output | 1 | One-cycle result strobe |
| res_code | output | 32 | Decoded code, or 0xFFFFFFFF on error |
| res_valid | output | 1 | Command byte matches its complement |

## Verification
The states that are hardest to reach from the ports are those where a threshold only shows up through accumulation. Three cases need this:
- a leader that passes only because of the start-up credit;
- a leading space that is rejected and then checked again;
- a data space whose raw sum would wrap past 255.

The stimulus reaches each one by splitting runs into several symbols with chosen lengths. It also places pulses and spaces exactly on each threshold and one sample past it. The table frames vary the split size so that the run sums are exercised for every bit.

// File: rtl/nec_dec_pkg.sv
package nec_dec_pkg;

    typedef enum logic [2:0] {
        S_HUNT,
        S_GAP,
        S_MARK,
        S_SPACE,
        S_FULL,
        S_FAULT
    } dec_state_t;

    typedef enum logic [2:0] {
        ACC_HOLD,
        ACC_ADD,
        ACC_LOAD,
        ACC_ZERO,
        ACC_CREDIT
    } acc_op_t;

endpackage

// File: rtl/nec_run_acc.sv
module nec_run_acc
    import nec_dec_pkg::*;
#(
    parameter int LEN_W  = 7,
    parameter int ACC_W  = 8,
    parameter int CREDIT = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_op_t          op,
    input  logic [LEN_W-1:0] len,
    output logic [ACC_W-1:0] acc
);
    localparam int SUM_W = ACC_W + 1;
    localparam logic [ACC_W-1:0] CREDIT_V = ACC_W'(CREDIT);

    logic [SUM_W-1:0] inc;
    logic [SUM_W-1:0] sum;

    function automatic logic [ACC_W-1:0] clamp(input logic [SUM_W-1:0] v);
        return v[ACC_W] ? '1 : v[ACC_W-1:0];
    endfunction

    assign inc = SUM_W'(len) + SUM_W'(1);
    assign sum = {1'b0, acc} + inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= CREDIT_V;
        end else begin
            unique case (op)
                ACC_ADD:    acc <= clamp(sum);
                ACC_LOAD:   acc <= clamp(inc);
                ACC_ZERO:   acc <= '0;
                ACC_CREDIT: acc <= CREDIT_V;
                default:    acc <= acc;
            endcase
        end
    end

endmodule

// File: rtl/nec_bit_collect.sv
module nec_bit_collect #(
    parameter int NBITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             bit_in,
    output logic [NBITS-1:0] code,
    output logic             last
);
    localparam int CNT_W = $clog2(NBITS);

    logic [CNT_W-1:0] cnt;

    assign last = (cnt == CNT_W'(NBITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (push)  cnt <= cnt + CNT_W'(1);
    end

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        logic b_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             b_q <= 1'b0;
            else if (clear)                         b_q <= 1'b0;
            else if (push && cnt == CNT_W'(i))      b_q <= bit_in;
        end
        assign code[i] = b_q;
    end

endmodule

// File: rtl/nec_frame_decoder.sv
module nec_frame_decoder
    import nec_dec_pkg::*;
#(
    parameter int LEN_W         = 7,
    parameter int ACC_W         = 8,
    parameter int NBITS         = 32,
    parameter int CREDIT        = 80,
    parameter int LEAD_MARK_MIN = 80,
    parameter int LEAD_GAP_MIN  = 40,
    parameter int MARK_MAX      = 26,
    parameter int SPACE_ONE_MIN = 26,
    parameter int SPACE_MAX     = 53
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    output logic             sym_ready,
    input  logic [LEN_W:0]   sym_data,
    input  logic             sym_eop,
    output logic             res_strobe,
    output logic [NBITS-1:0] res_code,
    output logic             res_valid
);
    localparam int BYTE_W = NBITS / 4;
    localparam logic [ACC_W-1:0] T_LEAD  = ACC_W'(LEAD_MARK_MIN);
    localparam logic [ACC_W-1:0] T_GAP   = ACC_W'(LEAD_GAP_MIN);
    localparam logic [ACC_W-1:0] T_MARK  = ACC_W'(MARK_MAX);
    localparam logic [ACC_W-1:0] T_ONE   = ACC_W'(SPACE_ONE_MIN);
    localparam logic [ACC_W-1:0] T_SPACE = ACC_W'(SPACE_MAX);

    dec_state_t       st, st_n;
    acc_op_t          op;
    logic [ACC_W-1:0] acc;
    logic [NBITS-1:0] code;
    logic             last, push, bit_v, clr, fin;
    logic             beat, is_mark;
    logic [NBITS-1:0] fin_code;

    function automatic logic cmd_match(input logic [NBITS-1:0] c);
        return (c[2*BYTE_W +: BYTE_W] ^ c[3*BYTE_W +: BYTE_W]) == '1;
    endfunction

    assign sym_ready = 1'b1;
    assign beat      = sym_valid & sym_ready;
    assign is_mark   = sym_data[LEN_W];

    nec_run_acc #(.LEN_W(LEN_W), .ACC_W(ACC_W), .CREDIT(CREDIT)) u_acc (
        .clk(clk), .rst_n(rst_n), .op(op), .len(sym_data[LEN_W-1:0]), .acc(acc)
    );

    nec_bit_collect #(.NBITS(NBITS)) u_bits (
        .clk(clk), .rst_n(rst_n), .clear(clr), .push(push),
        .bit_in(bit_v), .code(code), .last(last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_HUNT;
        else        st <= st_n;
    end

    // next state and datapath controls
    always_comb begin
        st_n  = st;
        op    = ACC_HOLD;
        push  = 1'b0;
        bit_v = 1'b0;
        clr   = 1'b0;
        fin   = 1'b0;
        if (beat && sym_eop) begin
            st_n = S_HUNT;
            op   = ACC_CREDIT;
            clr  = 1'b1;
            fin  = 1'b1;
        end else if (beat) begin
            unique case (st)
                S_HUNT: begin
                    if (is_mark)          op = ACC_ADD;
                    else if (acc > T_LEAD) begin
                        st_n = S_GAP;
                        op   = ACC_LOAD;
                    end else              op = ACC_ZERO;
                end
                S_GAP: begin
                    if (!is_mark)         op = ACC_ADD;
                    else if (acc > T_GAP) begin
                        st_n = S_MARK;
                        op   = ACC_LOAD;
                    end else              op = ACC_ZERO;
                end
                S_MARK: begin
                    if (is_mark)           op = ACC_ADD;
                    else if (acc > T_MARK) st_n = S_FAULT;
                    else begin
                        st_n = S_SPACE;
                        op   = ACC_LOAD;
                    end
                end
                S_SPACE: begin
                    if (!is_mark)           op = ACC_ADD;
                    else if (acc > T_SPACE) st_n = S_FAULT;
                    else begin
                        push  = 1'b1;
                        bit_v = (acc > T_ONE);
                        st_n  = last ? S_FULL : S_MARK;
                        op    = ACC_LOAD;
                    end
                end
                default: ;
            endcase
        end
    end

    assign fin_code = (st == S_MARK || st == S_SPACE || st == S_FULL) ? code : '1;

    // result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_strobe <= 1'b0;
            res_code   <= '0;
            res_valid  <= 1'b0;
        end else begin
            res_strobe <= fin;
            if (fin) begin
                res_code  <= fin_code;
                res_valid <= cmd_match(fin_code);
            end
        end
    end

endmodule

// File: rtl/nec_frame_decoder_chk.sv
module nec_frame_decoder_chk
    import nec_dec_pkg::*;
#(
    parameter int NBITS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_valid,
    input logic             sym_ready,
    input logic             sym_eop,
    input logic             res_strobe,
    input logic [NBITS-1:0] res_code,
    input logic             res_valid,
    input dec_state_t       st
);
    localparam int BYTE_W = NBITS / 4;

    logic end_beat;
    assign end_beat = sym_valid && sym_ready && sym_eop;

    assert_strobe_follows_eop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        end_beat |=> res_strobe);

    assert_strobe_needs_eop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_strobe |-> $past(end_beat));

    assert_hunt_after_eop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        end_beat |=> (st == S_HUNT));

    assert_valid_complement_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_strobe && res_valid) |->
            ((res_code[2*BYTE_W +: BYTE_W] ^ res_code[3*BYTE_W +: BYTE_W]) == '1));

    assert_error_not_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_strobe && res_code == '1) |-> !res_valid);

    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FAULT && !end_beat) |=> (st == S_FAULT));

    assert_full_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FULL && !end_beat) |=> (st == S_FULL));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R11: assert (!res_strobe && !res_valid && res_code == '0);
        end
    end

endmodule

bind nec_frame_decoder nec_frame_decoder_chk #(.NBITS(NBITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_eop(sym_eop), .res_strobe(res_strobe), .res_code(res_code),
    .res_valid(res_valid), .st(st)
);

// File: tb/sim_nec_frame_decoder.sv
`timescale 1ns/1ps
module sim_nec_frame_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic        sym_ready;
    logic [7:0]  sym_data = 8'h00;
    logic        sym_eop = 1'b0;
    logic        res_strobe;
    logic [31:0] res_code;
    logic        res_valid;

    int vec = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nec_frame_decoder u0 (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
        .sym_data(sym_data), .sym_eop(sym_eop), .res_strobe(res_strobe),
        .res_code(res_code), .res_valid(res_valid)
    );

    localparam int NV = 6;
    localparam logic [31:0] V_CODE [NV] = '{32'hBF40EF10, 32'h7F8000FF, 32'h12345678,
                                            32'hFF001234, 32'h00000000, 32'hAA55AA55};
    localparam bit          V_OK   [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam int          V_SPL  [NV] = '{128, 5, 128, 7, 128, 3};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sym(input bit lvl, input int n);
        sym_valid = 1'b1;
        sym_eop   = 1'b0;
        sym_data  = {lvl, 7'(n - 1)};
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic run(input bit lvl, input int total, input int chunk);
        int left;
        left = total;
        while (left > 0) begin
            int c;
            c = (left > chunk) ? chunk : left;
            sym(lvl, c);
            left -= c;
        end
    endtask

    task automatic leader();
        run(1'b1, 200, 100);
        run(1'b0, 100, 128);
    endtask

    task automatic body(input logic [31:0] code, input int n, input int chunk, input int plen);
        for (int i = 0; i < n; i++) begin
            run(1'b1, plen, chunk);
            run(1'b0, code[i] ? 36 : 12, chunk);
        end
        run(1'b1, plen, chunk);
    endtask

    task automatic endp(input string req, input logic [31:0] exp_code, input bit exp_ok);
        sym_valid = 1'b1;
        sym_eop   = 1'b1;
        sym_data  = 8'hC5;
        @(negedge clk);
        sym_valid = 1'b0;
        sym_eop   = 1'b0;
        chk({req, " strobe"}, {31'b0, res_strobe}, 32'd1);
        chk({req, " code"}, res_code, exp_code);
        chk({req, " valid"}, {31'b0, res_valid}, {31'b0, exp_ok});
        @(negedge clk);
        chk({req, " strobe low"}, {31'b0, res_strobe}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 strobe", {31'b0, res_strobe}, 32'd0);
        chk("R11 code", res_code, 32'd0);
        chk("R11 valid", {31'b0, res_valid}, 32'd0);
        chk("R11 ready", {31'b0, sym_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // table of frames: R6 bit order, R8 complement check, R1 split runs
        for (int v = 0; v < NV; v++) begin
            leader();
            body(V_CODE[v], 32, V_SPL[v], 10);
            endp("R6 R8 R1 table", V_CODE[v], V_OK[v]);
        end

        // R10 empty packet right after a result, stays in leader search
        endp("R10 R3 empty", 32'hFFFFFFFF, 1'b0);

        // R2 credit: one-sample pulse passes on credit
        run(1'b1, 1, 128); run(1'b0, 50, 128);
        body(32'hBF40EF10, 32, 128, 10);
        endp("R2 credit", 32'hBF40EF10, 1'b1);

        // R2 cleared count: short pulse rejected, later long pulse accepted
        run(1'b0, 10, 128); run(1'b1, 60, 128); run(1'b0, 10, 128);
        run(1'b1, 90, 128); run(1'b0, 100, 128);
        body(32'h7F8000FF, 32, 128, 10);
        endp("R2 retry", 32'h7F8000FF, 1'b1);

        // R2 boundary: exactly 80 after clear is not a leader
        run(1'b0, 5, 128); run(1'b1, 80, 128); run(1'b0, 50, 128); run(1'b1, 10, 128);
        endp("R2 boundary", 32'hFFFFFFFF, 1'b0);

        // R3 space of exactly 40 rejected, then 41 accepted
        run(1'b1, 200, 100); run(1'b0, 40, 128); run(1'b1, 10, 128); run(1'b0, 41, 128);
        body(32'hAA55AA55, 32, 128, 10);
        endp("R3 gap retry", 32'hAA55AA55, 1'b1);

        // R3 packet ends in the leading space
        run(1'b1, 200, 100); run(1'b0, 30, 128);
        endp("R3 gap end", 32'hFFFFFFFF, 1'b0);

        // R4 pulses of exactly 26 split 13+13
        leader();
        body(32'hBF40EF10, 32, 13, 26);
        endp("R4 pulse 26", 32'hBF40EF10, 1'b1);

        // R4 pulse 27 is an error; R7 later symbols ignored
        leader();
        run(1'b1, 27, 128); run(1'b0, 12, 128);
        body(32'hBF40EF10, 32, 128, 10);
        endp("R4 R7 pulse 27", 32'hFFFFFFFF, 1'b0);

        // R5 thresholds 27 -> 1, 26 -> 0, 53 -> 1; R9 partial
        leader();
        run(1'b1, 10, 128); run(1'b0, 27, 128);
        run(1'b1, 10, 128); run(1'b0, 26, 128);
        run(1'b1, 10, 128); run(1'b0, 53, 128);
        run(1'b1, 10, 128);
        endp("R5 R9 thresholds", 32'h00000005, 1'b0);

        // R5 space 54 is an error
        leader();
        run(1'b1, 10, 128); run(1'b0, 54, 128); run(1'b1, 10, 128);
        endp("R5 space 54", 32'hFFFFFFFF, 1'b0);

        // R6 symbols after 32 bits ignored
        leader();
        body(32'hAA55AA55, 32, 128, 10);
        run(1'b0, 50, 128); run(1'b1, 100, 128); run(1'b0, 200, 100); run(1'b1, 5, 128);
        endp("R6 tail ignored", 32'hAA55AA55, 1'b1);

        // R9 partial frames
        leader();
        body(32'hFFFFFFFF, 24, 128, 10);
        endp("R9 partial 24", 32'h00FFFFFF, 1'b1);
        leader();
        body(32'hFFFFFFFF, 8, 128, 10);
        endp("R9 partial 8", 32'h000000FF, 1'b0);

        // R1 saturation: space 128+128+10 must not wrap to 10
        leader();
        run(1'b1, 10, 128); run(1'b0, 266, 128); run(1'b1, 10, 128);
        endp("R1 saturate", 32'hFFFFFFFF, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vec++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

endmodule